// File: doc/BRIEF.md
# TMDS Lane Test Pattern Generator

This block is a self-test source placed in front of the serializer of a 10-bit TMDS lane. Each clock it produces one 10-bit character. A selector chooses what that character is: constant zero, the normal encoded character arriving from the encoder, a pseudo-random (PRBS) word, or a word taken from a programmable 80-bit rotating pattern. All four sources reach the output with the same two-cycle latency, so the selector can be changed without a timing skew between sources.

The PRBS source has four polynomials and can fill the character with 1, 8 or 10 fresh bits per cycle, or sit idle. The rotating pattern is eight 10-bit words. They are sent in a fixed order, and each word is held for a programmable number of cycles. A separate 40-bit clock pattern register feeds a clock lane. It is loaded in one cycle. It can then be rotated by one 10-bit slice per cycle, which serves a clock lane running at a quarter of the character rate.

Top module: `tmds_bist_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after its release, `lane_out` and `clk_pttn_out` are zero.
- R2: `out_sel` picks the source: 3'b000 zero, 3'b001 `enc_data_in`, 3'b010 PRBS word, 3'b100 shift word, and any other code gives zero. A source value generated from inputs sampled at rising edge N appears on `lane_out` after edge N+1, provided `out_sel` is held over both edges.
- R3: `prbs_mode` selects the PRBS polynomial: 0 gives x^11+x^9+1, 1 gives x^15+x^14+1, 2 gives x^7+x^6+1, and 3 gives x^31+x^28+1. For a polynomial x^n+x^t+1, each new bit is the XOR of the bits produced n and t steps earlier.
- R4: While `prbs_en` is low, the PRBS word is zero and the generator is re-seeded so that its n most recent bits are all ones. The first enabled cycle emits the first bits after that seed.
- R5: `prbs_width` sets the number of bits per cycle: 0 gives none, 1 gives 8 bits, 2 gives 1 bit and 3 gives 10 bits. Bit 0 of the word holds the earliest bit, and word bits at or above the width are zero.
- R6: With `shift_en` high, the shift word sequence is bits 79:70, 69:60, down to 9:0 of `shift_pattern`, and then it wraps to 79:70. While `shift_en` is low, the shift word is zero and the sequence restarts at 79:70.
- R7: `shift_repeat` value k holds each shift word for exactly k+1 cycles.
- R8: When `clk_pttn_load` is high, the 40-bit clock pattern register takes `clk_pttn_in`, and `clk_pttn_out` shows bits 9:0 of the register after that edge. Load takes priority over a shift request in the same cycle.
- R9: When `clk_pttn_shift` is high and `clk_pttn_load` is low, the register rotates right by 10 bits, so `clk_pttn_out` steps through slices 19:10, 29:20, 39:30 and back to 9:0. With neither control high, the register holds.
- R10: An idle PRBS width does not advance the generator. When a nonzero width resumes, the sequence continues from the bit after the last one emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low synchronous reset |
| out_sel | input | 3 | Output source select |
| enc_data_in | input | 10 | Normal encoded TMDS character |
| prbs_en | input | 1 | PRBS generator enable |
| prbs_mode | input | 2 | PRBS polynomial select |
| prbs_width | input | 2 | PRBS bits per cycle select |
| shift_en | input | 1 | Shift pattern generator enable |
| shift_repeat | input | 3 | Cycles per shift word, minus one |
| shift_pattern | input | 80 | Eight 10-bit shift words, first word in the top bits |
| clk_pttn_load | input | 1 | Load the clock pattern register |
| clk_pttn_shift | input | 1 | Rotate the clock pattern register |
| clk_pttn_in | input | 40 | Clock pattern load value |
| lane_out | output | 10 | Selected test character |
| clk_pttn_out | output | 10 | Current clock pattern slice |

## Verification
The hardest state to reach from the ports is a PRBS sequence that resumes correctly after idle cycles in the middle of a run. The 31-bit polynomial makes this harder, because wrong tap placement only shows after many steps. The stimulus enables the generator from a re-seed, runs it at 1-bit width, switches to idle for several cycles and then returns to a nonzero width. It runs each polynomial long enough to pass its register length, and runs the 7-bit polynomial past its full period of 127. Expected bits come from a bit-history model in the bench that XORs earlier outputs. This model shares no structure with the register-and-tap form in the design.

// File: rtl/tmds_bist_pkg.sv
package tmds_bist_pkg;

  localparam int LFSR_W = 31;

  typedef enum logic [1:0] {
    PM_P11 = 2'd0,
    PM_P15 = 2'd1,
    PM_P7  = 2'd2,
    PM_P31 = 2'd3
  } prbs_mode_e;

  typedef enum logic [1:0] {
    PW_IDLE = 2'd0,
    PW_8    = 2'd1,
    PW_1    = 2'd2,
    PW_10   = 2'd3
  } prbs_width_e;

  localparam logic [2:0] OS_ZERO  = 3'b000;
  localparam logic [2:0] OS_DATA  = 3'b001;
  localparam logic [2:0] OS_PRBS  = 3'b010;
  localparam logic [2:0] OS_SHIFT = 3'b100;

  // one Fibonacci step: newest bit enters at bit 0
  function automatic logic [LFSR_W-1:0] lfsr_adv(input logic [LFSR_W-1:0] s,
                                                 input prbs_mode_e m);
    logic fb;
    case (m)
      PM_P11:  fb = s[10] ^ s[8];
      PM_P15:  fb = s[14] ^ s[13];
      PM_P7:   fb = s[6]  ^ s[5];
      default: fb = s[30] ^ s[27];
    endcase
    return {s[LFSR_W-2:0], fb};
  endfunction

  function automatic int unsigned width_steps(input prbs_width_e w);
    case (w)
      PW_8:    return 8;
      PW_1:    return 1;
      PW_10:   return 10;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/tmds_prbs_gen.sv
module tmds_prbs_gen
  import tmds_bist_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [1:0]        mode,
  input  logic [1:0]        width,
  output logic [WORD_W-1:0] word_q,
  output logic              step_evt
);

  prbs_mode_e  mode_e;
  prbs_width_e width_e;
  logic [LFSR_W-1:0] state;
  logic [LFSR_W-1:0] nxt;
  logic [WORD_W-1:0] bits;

  assign mode_e   = prbs_mode_e'(mode);
  assign width_e  = prbs_width_e'(width);
  assign step_evt = en && (width_e != PW_IDLE);

  always_comb begin
    nxt  = state;
    bits = '0;
    for (int i = 0; i < WORD_W; i++) begin
      if (i < int'(width_steps(width_e))) begin
        nxt     = lfsr_adv(nxt, mode_e);
        bits[i] = nxt[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      state  <= '1;
      word_q <= '0;
    end else begin
      state  <= nxt;
      word_q <= bits;
    end
  end

  p_no_lockup_r4: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $past(width) == PW_IDLE) |-> $stable(state));

  p_single_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && $past(width) == PW_1) |-> (word_q[WORD_W-1:1] == '0));

  p_off_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (word_q == '0));

endmodule

// File: rtl/tmds_shift_gen.sv
module tmds_shift_gen #(
  parameter int WORD_W = 10,
  parameter int NWORDS = 8,
  parameter int REP_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic [REP_W-1:0]         repeat_k,
  input  logic [WORD_W*NWORDS-1:0] pattern,
  output logic [WORD_W-1:0]        word_q,
  output logic                     word_adv
);

  localparam int PAT_W = WORD_W * NWORDS;
  localparam int IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NWORDS - 1);

  logic [WORD_W-1:0] words [NWORDS];
  logic [IDX_W-1:0]  idx;
  logic [REP_W-1:0]  hold;

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    assign words[g] = pattern[PAT_W-1-g*WORD_W -: WORD_W];
  end

  assign word_adv = en && (hold >= repeat_k);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      idx    <= '0;
      hold   <= '0;
      word_q <= '0;
    end else begin
      word_q <= words[idx];
      if (word_adv) begin
        hold <= '0;
        idx  <= (idx == LAST) ? '0 : idx + 1'b1;
      end else begin
        hold <= hold + 1'b1;
      end
    end
  end

  p_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $past(word_adv)) |->
      (idx == (($past(idx) == LAST) ? '0 : $past(idx) + 1'b1)));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$past(word_adv)) |-> $stable(idx));

  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (idx == '0 && word_q == '0));

endmodule

// File: rtl/tmds_clk_pttn.sv
module tmds_clk_pttn #(
  parameter int SLICE_W = 10,
  parameter int SLICES  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic                       shift,
  input  logic [SLICE_W*SLICES-1:0]  load_val,
  output logic [SLICE_W-1:0]         slice
);

  localparam int PAT_W = SLICE_W * SLICES;

  logic [PAT_W-1:0] pat_q;
  logic [PAT_W-1:0] rotated;

  if (SLICES > 1) begin : g_rot
    assign rotated = {pat_q[SLICE_W-1:0], pat_q[PAT_W-1:SLICE_W]};
  end else begin : g_norot
    assign rotated = pat_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     pat_q <= '0;
    else if (load)  pat_q <= load_val;
    else if (shift) pat_q <= rotated;
  end

  assign slice = pat_q[SLICE_W-1:0];

  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (slice == $past(load_val[SLICE_W-1:0])));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift) |=> $stable(pat_q));

endmodule

// File: rtl/tmds_bist_gen.sv
module tmds_bist_gen
  import tmds_bist_pkg::*;
#(
  parameter int WORD_W     = 10,
  parameter int NWORDS     = 8,
  parameter int REP_W      = 3,
  parameter int CLK_SLICES = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [2:0]                   out_sel,
  input  logic [WORD_W-1:0]            enc_data_in,
  input  logic                         prbs_en,
  input  logic [1:0]                   prbs_mode,
  input  logic [1:0]                   prbs_width,
  input  logic                         shift_en,
  input  logic [REP_W-1:0]             shift_repeat,
  input  logic [WORD_W*NWORDS-1:0]     shift_pattern,
  input  logic                         clk_pttn_load,
  input  logic                         clk_pttn_shift,
  input  logic [WORD_W*CLK_SLICES-1:0] clk_pttn_in,
  output logic [WORD_W-1:0]            lane_out,
  output logic [WORD_W-1:0]            clk_pttn_out
);

  logic [WORD_W-1:0] prbs_word;
  logic [WORD_W-1:0] shift_word;
  logic [WORD_W-1:0] enc_q;
  logic              prbs_step;
  logic              shift_adv;
  logic              sel_legal;

  tmds_prbs_gen #(.WORD_W(WORD_W)) u_prbs (
    .clk(clk), .rst_n(rst_n), .en(prbs_en), .mode(prbs_mode),
    .width(prbs_width), .word_q(prbs_word), .step_evt(prbs_step)
  );

  tmds_shift_gen #(.WORD_W(WORD_W), .NWORDS(NWORDS), .REP_W(REP_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .en(shift_en), .repeat_k(shift_repeat),
    .pattern(shift_pattern), .word_q(shift_word), .word_adv(shift_adv)
  );

  tmds_clk_pttn #(.SLICE_W(WORD_W), .SLICES(CLK_SLICES)) u_clkp (
    .clk(clk), .rst_n(rst_n), .load(clk_pttn_load), .shift(clk_pttn_shift),
    .load_val(clk_pttn_in), .slice(clk_pttn_out)
  );

  assign sel_legal = (out_sel == OS_ZERO) || (out_sel == OS_DATA) ||
                     (out_sel == OS_PRBS) || (out_sel == OS_SHIFT);

  // aligns the pass-through path with the registered generators
  always_ff @(posedge clk) begin
    if (!rst_n) enc_q <= '0;
    else        enc_q <= enc_data_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lane_out <= '0;
    else begin
      case (out_sel)
        OS_DATA:  lane_out <= enc_q;
        OS_PRBS:  lane_out <= prbs_word;
        OS_SHIFT: lane_out <= shift_word;
        default:  lane_out <= '0;
      endcase
    end
  end

  p_bad_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_legal |=> (lane_out == '0));

  p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sel == OS_DATA) |=> (lane_out == $past(enc_q)));

  p_prbs_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sel == OS_PRBS) |=> (lane_out == $past(prbs_word)));

endmodule

// File: tb/sim_tmds_bist_gen.sv
module sim_tmds_bist_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  out_sel = '0;
  logic [9:0]  enc_data_in = '0;
  logic        prbs_en = 1'b0;
  logic [1:0]  prbs_mode = '0;
  logic [1:0]  prbs_width = '0;
  logic        shift_en = 1'b0;
  logic [2:0]  shift_repeat = '0;
  logic [79:0] shift_pattern = '0;
  logic        clk_pttn_load = 1'b0;
  logic        clk_pttn_shift = 1'b0;
  logic [39:0] clk_pttn_in = '0;
  logic [9:0]  lane_out;
  logic [9:0]  clk_pttn_out;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  typedef struct {
    int         due;
    bit         clk_lane;
    logic [9:0] val;
    string      req;
  } exp_t;
  exp_t sb[$];

  bit hist[$];
  int pn, pt;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tmds_bist_gen u0 (
    .clk(clk), .rst_n(rst_n), .out_sel(out_sel), .enc_data_in(enc_data_in),
    .prbs_en(prbs_en), .prbs_mode(prbs_mode), .prbs_width(prbs_width),
    .shift_en(shift_en), .shift_repeat(shift_repeat),
    .shift_pattern(shift_pattern), .clk_pttn_load(clk_pttn_load),
    .clk_pttn_shift(clk_pttn_shift), .clk_pttn_in(clk_pttn_in),
    .lane_out(lane_out), .clk_pttn_out(clk_pttn_out)
  );

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic expect_val(input logic [9:0] v, input string r,
                            input bit on_clk, input int lat);
    exp_t e;
    e.due = cyc + lat; e.clk_lane = on_clk; e.val = v; e.req = r;
    sb.push_back(e);
  endtask

  // monitor: pop and compare items that fall due on this cycle
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      logic [9:0] got;
      e = sb.pop_front();
      got = e.clk_lane ? clk_pttn_out : lane_out;
      total++;
      if (e.due != cyc || got !== e.val) begin
        bad++;
        $display("FAIL %s cyc=%0d due=%0d %s got=%h exp=%h", e.req, cyc,
                 e.due, e.clk_lane ? "clk" : "lane", got, e.val);
      end
    end
  end

  function automatic void model_seed(input int mode);
    case (mode)
      0: begin pn = 11; pt = 9;  end
      1: begin pn = 15; pt = 14; end
      2: begin pn = 7;  pt = 6;  end
      default: begin pn = 31; pt = 28; end
    endcase
    hist.delete();
    for (int i = 0; i < pn; i++) hist.push_back(1'b1);
  endfunction

  function automatic bit model_bit();
    bit b;
    b = hist[hist.size() - pn] ^ hist[hist.size() - pt];
    hist.push_back(b);
    if (hist.size() > 40) void'(hist.pop_front());
    return b;
  endfunction

  task automatic prbs_cycles(input int w, input int n, input string r);
    prbs_width = w[1:0];
    for (int c = 0; c < n; c++) begin
      logic [9:0] v;
      int nb;
      v = '0;
      nb = (w == 1) ? 8 : (w == 2) ? 1 : (w == 3) ? 10 : 0;
      for (int b = 0; b < nb; b++) v[b] = model_bit();
      expect_val(v, r, 1'b0, 2);
      tick();
    end
  endtask

  task automatic run_prbs(input int mode, input int w, input int n, input string r);
    out_sel = 3'b010;
    prbs_en = 1'b0;
    prbs_mode = mode[1:0];
    model_seed(mode);
    tick();
    prbs_en = 1'b1;
    prbs_cycles(w, n, r);
  endtask

  task automatic run_shift(input int k, input int n, input string r);
    out_sel = 3'b100;
    shift_en = 1'b0;
    shift_repeat = k[2:0];
    tick();
    shift_en = 1'b1;
    for (int j = 0; j < n; j++) begin
      int wi;
      wi = (j / (k + 1)) % 8;
      expect_val(10'((shift_pattern >> (70 - 10 * wi)) & 80'h3FF), r, 1'b0, 2);
      tick();
    end
  endtask

  task automatic drain();
    repeat (4) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired at cyc=%0d", cyc);
    summary();
    $finish;
  end

  initial begin
    repeat (4) tick();
    // R1: reset values
    total++;
    if (lane_out !== '0 || clk_pttn_out !== '0) begin
      bad++;
      $display("FAIL R1 lane=%h clk=%h exp=000", lane_out, clk_pttn_out);
    end
    rst_n = 1'b1;
    expect_val(10'h000, "R1", 1'b0, 1);
    expect_val(10'h000, "R1", 1'b1, 1);
    tick();

    // R2: pass-through of encoded data
    out_sel = 3'b001;
    for (int i = 0; i < 6; i++) begin
      enc_data_in = 10'((i * 163 + 37) & 10'h3FF);
      expect_val(enc_data_in, "R2", 1'b0, 2);
      tick();
    end
    drain();
    // R2: zero and unlisted codes give zero
    enc_data_in = 10'h3A5;
    out_sel = 3'b000;
    repeat (3) begin expect_val(10'h000, "R2", 1'b0, 2); tick(); end
    drain();
    out_sel = 3'b011;
    repeat (3) begin expect_val(10'h000, "R2", 1'b0, 2); tick(); end
    drain();
    out_sel = 3'b111;
    repeat (3) begin expect_val(10'h000, "R2", 1'b0, 2); tick(); end
    drain();

    // R3/R4/R5: each polynomial and width
    run_prbs(2, 2, 140, "R3");
    run_prbs(0, 1, 30, "R3");
    run_prbs(1, 3, 30, "R5");
    run_prbs(3, 3, 40, "R3");
    run_prbs(3, 2, 70, "R4");
    // R10: idle holds, then resume
    run_prbs(0, 2, 20, "R10");
    prbs_cycles(0, 5, "R10");
    prbs_cycles(2, 20, "R10");
    prbs_cycles(0, 3, "R10");
    prbs_cycles(1, 10, "R5");
    drain();
    prbs_en = 1'b0;

    // R6/R7: shift sequencing and hold counts
    shift_pattern = 80'hA5C3_1F0E_9D27_64B8_05F1;
    run_shift(0, 20, "R6");
    run_shift(2, 30, "R7");
    run_shift(7, 70, "R7");
    drain();
    shift_en = 1'b0;
    drain();

    // R8/R9: clock pattern load and rotation
    clk_pttn_in = 40'hC3_5A96_0F1E;
    clk_pttn_load = 1'b1;
    expect_val(clk_pttn_in[9:0], "R8", 1'b1, 1);
    tick();
    clk_pttn_load = 1'b0;
    clk_pttn_shift = 1'b1;
    for (int s = 1; s <= 5; s++) begin
      expect_val(10'((clk_pttn_in >> (10 * (s % 4))) & 40'h3FF), "R9", 1'b1, 1);
      tick();
    end
    clk_pttn_shift = 1'b0;
    repeat (2) begin
      expect_val(clk_pttn_in[19:10], "R9", 1'b1, 1);
      tick();
    end
    clk_pttn_in = 40'h12_3456_789A;
    clk_pttn_load = 1'b1;
    clk_pttn_shift = 1'b1;
    expect_val(clk_pttn_in[9:0], "R8", 1'b1, 1);
    tick();
    clk_pttn_load = 1'b0;
    clk_pttn_shift = 1'b0;
    drain();

    summary();
    $finish;
  end

endmodule